// File: doc/BRIEF.md
# Implicit-Acknowledgement Membership Tracker

This block keeps one node's view of which nodes on a time-division broadcast bus are still members. It also decides when that node has to go quiet. The bus runs a fixed schedule of slots, and every slot belongs to one sender. The block is told when each slot starts and whose slot it is. For each frame heard, it is told whether the frame arrived intact and what the frame's two acknowledgement bits say. The first bit is the sender's verdict on the node that sent just before it. The second bit is its verdict on the node two senders back.

Every intact frame adds to a per-round accept count. A missing or corrupt frame adds to a reject count and removes that slot's owner from the membership vector. When the node's own slot begins, it checks whether it belongs to the majority. If accepts do not outnumber rejects, the node is in a minority clique. It then drops itself from its own membership and raises a permanent silence request. In both cases the two counters restart for the next round.

After each frame it sends, the node watches the next two frames. If neither of them confirms its transmission, it treats itself as faulty and goes silent in the same way. CRC generation and checking happen outside this block. Only their verdict arrives, on `frame_ok`.

Top module: `impl_ack_membership`

## Requirements
- R1: After reset, every bit of `member_vec` is 1, both counters are 0 and `silence_req` is 0. The current slot owner is taken to be the node itself until the first slot start.
- R2: A frame with `frame_valid`=1 and `frame_ok`=1 in another node's slot adds one to `accept_cnt`. The count saturates at 2^CNT_W-1, and `member_vec` does not change.
- R3: A frame with `frame_valid`=1 and `frame_ok`=0 in another node's slot adds one to `reject_cnt`, saturating at 2^CNT_W-1. It also clears bit `slot_idx` of the slot owner in `member_vec`.
- R4: `frame_valid` during the node's own slot (slot index equal to SELF_ID) leaves all outputs unchanged.
- R5: At the start of the own slot, if the node is active and `accept_cnt` <= `reject_cnt`, then `silence_req` rises and `member_vec[SELF_ID]` clears. At every own slot start, both counters return to 0.
- R6: At the start of the own slot, if the node is active and `accept_cnt` > `reject_cnt`, the node stays active and is taken to have sent a frame in that slot.
- R7: After a sent frame, the next two frames heard in other slots are its successors. The first successor confirms the frame if it is intact with `ack_prev1`=1. The second successor confirms it if it is intact with `ack_prev2`=1. The acknowledgement bits of a corrupt frame confirm nothing. If the second successor arrives without any confirmation, `silence_req` rises and `member_vec[SELF_ID]` clears.
- R8: `silence_req` stays at 1 until reset. A silent node sends no further frames, so no acknowledgement is judged for it and no clique check is made.
- R9: A cleared membership bit is set again only by reset.
- R10: Every output takes its new value in the clock cycle after the strobe (`slot_start` or `frame_valid`) that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_start | input | 1 | Single-cycle strobe marking the beginning of a slot |
| slot_idx | input | IDX_W | Owner of the slot that is starting; sampled with `slot_start` |
| frame_valid | input | 1 | Single-cycle strobe: the frame for the current slot has been evaluated; never together with `slot_start` |
| frame_ok | input | 1 | 1 when the frame arrived intact, 0 when it was missing or corrupt |
| ack_prev1 | input | 1 | Frame's verdict on the immediately preceding sender |
| ack_prev2 | input | 1 | Frame's verdict on the sender two back |
| member_vec | output | N_NODES | One bit per node, 1 while that node is considered a member |
| accept_cnt | output | CNT_W | Intact frames since the last own slot |
| reject_cnt | output | CNT_W | Missing or corrupt frames since the last own slot |
| silence_req | output | 1 | Sticky request for the node to stop transmitting |

## Verification
A wrong acknowledgement window state appears as `silence_req` rising, or failing to rise, on the cycle after the second successor frame. Such a fault is therefore visible within two frames of each own transmission. A corrupted count shows up directly on `accept_cnt` or `reject_cnt` one cycle after the frame. It also leads to a wrong clique verdict on `silence_req` at the next own slot, at most one round later. A wrong slot owner register shows as a membership bit cleared at the wrong position, or as an own-slot frame that changes a counter, one cycle after the offending frame.

// File: rtl/mt_pkg.sv
// Shared types of the membership tracker.
package mt_pkg;
    // State of the acknowledgement window that follows one own transmission.
    typedef enum logic [1:0] {
        WIN_IDLE  = 2'd0,   // no own frame awaiting a verdict
        WIN_LAST  = 2'd1,   // waiting for the second successor
        WIN_FIRST = 2'd2    // waiting for the first successor
    } ack_win_e;
endpackage

// File: rtl/mt_ack_window.sv
// Judges the node's last own frame from the two frames that follow it.
// The first successor's ack_prev1 and the second successor's ack_prev2 both
// refer to this node. A corrupt frame still counts as a successor but
// confirms nothing. ack_fail pulses combinationally on the second successor
// frame when no confirmation was seen.
// Assumes restart and frame_evt never occur in the same cycle.
module mt_ack_window
    import mt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,     // own slot begins
    input  logic arm,         // own frame goes out in this slot
    input  logic frame_evt,   // a frame from another node is evaluated
    input  logic frame_ok,
    input  logic ack_prev1,
    input  logic ack_prev2,
    output logic ack_fail
);
    ack_win_e win_q;
    logic     conf_q;
    logic     hit;
    logic     conf_n;

    // Confirmation offered by the frame being evaluated now.
    always_comb begin
        hit = frame_ok && (((win_q == WIN_FIRST) && ack_prev1) ||
                           ((win_q == WIN_LAST)  && ack_prev2));
        conf_n   = conf_q | hit;
        ack_fail = frame_evt && (win_q == WIN_LAST) && !conf_n;
    end

    // Window progression: armed at own slot, advanced by each successor frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= WIN_IDLE;
            conf_q <= 1'b0;
        end else if (restart) begin
            win_q  <= arm ? WIN_FIRST : WIN_IDLE;
            conf_q <= 1'b0;
        end else if (frame_evt && (win_q != WIN_IDLE)) begin
            conf_q <= conf_n;
            win_q  <= (win_q == WIN_FIRST) ? WIN_LAST : WIN_IDLE;
        end
    end

    // R7
    ack_window_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q == WIN_IDLE) && !restart |=> (win_q == WIN_IDLE));

    // R7
    ack_window_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q == WIN_FIRST) && frame_evt && !restart |=> (win_q == WIN_LAST));
endmodule

// File: rtl/mt_round_counters.sv
// Accept and reject counters for one round, saturating at all-ones.
// They clear when the own slot begins. majority is 1 while accepts strictly
// outnumber rejects.
// Assumes clear and the increments never coincide.
module mt_round_counters #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc_acc,
    input  logic             inc_rej,
    output logic [CNT_W-1:0] acc,
    output logic [CNT_W-1:0] rej,
    output logic             majority
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [1:0]            inc;
    logic [1:0][CNT_W-1:0] cnt_q;

    // Gather increment requests: index 0 accepts, index 1 rejects.
    always_comb begin
        inc = {inc_rej, inc_acc};
    end

    for (genvar k = 0; k < 2; k++) begin : g_cnt
        // Saturating counter cleared at the own slot.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                cnt_q[k] <= '0;
            else if (inc[k] && (cnt_q[k] != CNT_MAX))
                cnt_q[k] <= cnt_q[k] + 1'b1;
        end
    end

    // Output mapping and clique comparison.
    always_comb begin
        acc      = cnt_q[0];
        rej      = cnt_q[1];
        majority = cnt_q[0] > cnt_q[1];
    end

    // R5
    round_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc == '0) && (rej == '0));

    // R3
    reject_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_rej && !clear && (rej != CNT_MAX) |=> (rej == $past(rej) + 1'b1));

    // R2
    accept_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_acc && !clear && (acc == CNT_MAX) |=> (acc == CNT_MAX));
endmodule

// File: rtl/mt_member_vec.sv
// Membership vector: all ones after reset. A bit is cleared either when its
// node's frame is lost (drop_sender) or, for the node's own bit, on
// self-exclusion (drop_self). Nothing sets a bit again except reset.
module mt_member_vec #(
    parameter int N_NODES = 4,
    parameter int IDX_W   = 2,
    parameter int SELF_ID = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               drop_sender,
    input  logic [IDX_W-1:0]   sender,
    input  logic               drop_self,
    output logic [N_NODES-1:0] member
);
    for (genvar i = 0; i < N_NODES; i++) begin : g_bit
        logic hit_sender;
        logic hit_self;

        // Decode whether this bit is targeted in the current cycle.
        always_comb begin
            hit_sender = drop_sender && (sender == IDX_W'(i));
            hit_self   = drop_self && (i == SELF_ID);
        end

        // One-way membership bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                member[i] <= 1'b1;
            else if (hit_sender || hit_self)
                member[i] <= 1'b0;
        end

        // R9
        member_no_rejoin_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !member[i] |=> !member[i]);
    end
endmodule

// File: rtl/impl_ack_membership.sv
// Membership tracker with implicit acknowledgement and clique avoidance.
// It latches the owner of the current slot and classifies each frame
// strobe. It then drives the round counters, the membership vector and the
// acknowledgement window, and it holds the sticky silence request.
// Assumes slot_start and frame_valid are never high together.
module impl_ack_membership #(
    parameter int N_NODES = 4,
    parameter int SELF_ID = 1,
    parameter int CNT_W   = 4,
    localparam int IDX_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slot_start,
    input  logic [IDX_W-1:0]   slot_idx,
    input  logic               frame_valid,
    input  logic               frame_ok,
    input  logic               ack_prev1,
    input  logic               ack_prev2,
    output logic [N_NODES-1:0] member_vec,
    output logic [CNT_W-1:0]   accept_cnt,
    output logic [CNT_W-1:0]   reject_cnt,
    output logic               silence_req
);
    localparam logic [IDX_W-1:0] SELF_IDX = IDX_W'(SELF_ID);

    logic [IDX_W-1:0] cur_slot_q;
    logic             silence_q;
    logic             own_start;
    logic             frame_evt;
    logic             good_evt;
    logic             bad_evt;
    logic             majority;
    logic             clique_fail;
    logic             send_now;
    logic             ack_fail;

    // Remember whose slot is running; the node itself until the first slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_slot_q <= SELF_IDX;
        else if (slot_start)
            cur_slot_q <= slot_idx;
    end

    // Classify strobes and take the clique verdict at the own slot.
    always_comb begin
        own_start   = slot_start && (slot_idx == SELF_IDX);
        frame_evt   = frame_valid && (cur_slot_q != SELF_IDX);
        good_evt    = frame_evt && frame_ok;
        bad_evt     = frame_evt && !frame_ok;
        clique_fail = own_start && !silence_q && !majority;
        send_now    = own_start && !silence_q && majority;
    end

    // Sticky fail-silent request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            silence_q <= 1'b0;
        else if (clique_fail || ack_fail)
            silence_q <= 1'b1;
    end

    mt_round_counters #(.CNT_W(CNT_W)) i_counters (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (own_start),
        .inc_acc  (good_evt),
        .inc_rej  (bad_evt),
        .acc      (accept_cnt),
        .rej      (reject_cnt),
        .majority (majority)
    );

    mt_member_vec #(.N_NODES(N_NODES), .IDX_W(IDX_W), .SELF_ID(SELF_ID)) i_members (
        .clk         (clk),
        .rst_n       (rst_n),
        .drop_sender (bad_evt),
        .sender      (cur_slot_q),
        .drop_self   (clique_fail || ack_fail),
        .member      (member_vec)
    );

    mt_ack_window i_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (own_start),
        .arm       (send_now),
        .frame_evt (frame_evt),
        .frame_ok  (frame_ok),
        .ack_prev1 (ack_prev1),
        .ack_prev2 (ack_prev2),
        .ack_fail  (ack_fail)
    );

    assign silence_req = silence_q;

    // R8
    silence_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        silence_req |=> silence_req);

    // R7
    ack_fail_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fail |=> silence_req && !member_vec[SELF_ID]);

    // R5
    clique_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clique_fail |=> silence_req && !member_vec[SELF_ID]);

    // R4
    own_frame_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && !slot_start && (cur_slot_q == SELF_IDX) |=>
            $stable(member_vec) && $stable(accept_cnt) && $stable(reject_cnt)
            && $stable(silence_req));
endmodule

// File: tb/test_impl_ack_membership.sv
module test_impl_ack_membership;
    localparam int N_NODES = 4;
    localparam int SELF_ID = 1;
    localparam int CNT_W   = 4;
    localparam int IDX_W   = 2;
    localparam int CMAX    = (1 << CNT_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               slot_start = 1'b0;
    logic [IDX_W-1:0]   slot_idx = '0;
    logic               frame_valid = 1'b0;
    logic               frame_ok = 1'b0;
    logic               ack_prev1 = 1'b0;
    logic               ack_prev2 = 1'b0;
    logic [N_NODES-1:0] member_vec;
    logic [CNT_W-1:0]   accept_cnt;
    logic [CNT_W-1:0]   reject_cnt;
    logic               silence_req;

    impl_ack_membership #(.N_NODES(N_NODES), .SELF_ID(SELF_ID), .CNT_W(CNT_W)) i_impl_ack_membership (
        .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .slot_idx(slot_idx),
        .frame_valid(frame_valid), .frame_ok(frame_ok), .ack_prev1(ack_prev1),
        .ack_prev2(ack_prev2), .member_vec(member_vec), .accept_cnt(accept_cnt),
        .reject_cnt(reject_cnt), .silence_req(silence_req)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state derived from the requirements.
    logic [N_NODES-1:0] m_mem;
    int  m_acc, m_rej, m_cur, m_win;
    bit  m_sil, m_conf;

    function automatic void model_reset();
        m_mem = '1; m_acc = 0; m_rej = 0; m_cur = SELF_ID;
        m_win = 0; m_sil = 0; m_conf = 0;
    endfunction

    function automatic void model_slot(int idx);
        m_cur = idx;
        if (idx == SELF_ID) begin
            if (!m_sil) begin
                if (m_acc <= m_rej) begin
                    m_sil = 1; m_mem[SELF_ID] = 1'b0; m_win = 0;
                end else begin
                    m_win = 2; m_conf = 0;
                end
            end else m_win = 0;
            m_acc = 0; m_rej = 0;
        end
    endfunction

    function automatic void model_frame(bit ok, bit a1, bit a2);
        if (m_cur == SELF_ID) return;
        if (ok) begin
            if (m_acc < CMAX) m_acc++;
        end else begin
            if (m_rej < CMAX) m_rej++;
            m_mem[m_cur] = 1'b0;
        end
        if (m_win != 0) begin
            if (ok && ((m_win == 2 && a1) || (m_win == 1 && a2))) m_conf = 1;
            if (m_win == 1 && !m_conf) begin
                m_sil = 1; m_mem[SELF_ID] = 1'b0;
            end
            m_win--;
        end
    endfunction

    task automatic compare(string tag);
        n_checks++;
        if (member_vec !== m_mem || accept_cnt !== CNT_W'(m_acc) ||
            reject_cnt !== CNT_W'(m_rej) || silence_req !== m_sil) begin
            n_fail++;
            $display("FAIL %s: got mem=%b acc=%0d rej=%0d sil=%b exp mem=%b acc=%0d rej=%0d sil=%b",
                     tag, member_vec, accept_cnt, reject_cnt, silence_req,
                     m_mem, m_acc, m_rej, m_sil);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        model_reset();
        compare("R1");
    endtask

    // Strobe a slot start; results are visible one cycle later (R10).
    task automatic do_slot(int idx, string tag);
        @(negedge clk); slot_start = 1'b1; slot_idx = IDX_W'(idx);
        model_slot(idx);
        @(negedge clk); slot_start = 1'b0;
        compare(tag);
    endtask

    task automatic do_frame(bit ok, bit a1, bit a2, string tag);
        @(negedge clk); frame_valid = 1'b1; frame_ok = ok; ack_prev1 = a1; ack_prev2 = a2;
        model_frame(ok, a1, a2);
        @(negedge clk); frame_valid = 1'b0;
        compare(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        model_reset();
        do_reset();                                  // R1
        do_frame(1'b0, 1'b1, 1'b1, "R4");            // before any slot: own slot assumed
        // Round: good, good, bad from node 0, then own slot with majority.
        do_slot(2, "R10");
        do_frame(1'b1, 1'b1, 1'b1, "R2");
        do_slot(3, "R10");
        do_frame(1'b1, 1'b1, 1'b1, "R2");
        do_slot(0, "R10");
        do_frame(1'b0, 1'b1, 1'b1, "R3");
        do_slot(SELF_ID, "R6");
        do_frame(1'b0, 1'b0, 1'b0, "R4");            // own-slot frame ignored
        // Confirmation from the second successor only.
        do_slot(2, "R10");
        do_frame(1'b1, 1'b0, 1'b1, "R7");
        do_slot(3, "R10");
        do_frame(1'b1, 1'b1, 1'b1, "R7");
        do_slot(0, "R10");
        do_frame(1'b1, 1'b1, 1'b1, "R9");            // node 0 stays excluded
        do_slot(SELF_ID, "R6");
        // Neither successor confirms.
        do_slot(2, "R10");
        do_frame(1'b1, 1'b0, 1'b0, "R7");
        do_slot(3, "R10");
        do_frame(1'b1, 1'b0, 1'b0, "R7");
        do_slot(0, "R10");
        do_frame(1'b1, 1'b1, 1'b1, "R8");
        do_slot(SELF_ID, "R8");
        do_slot(2, "R8");
        do_frame(1'b1, 1'b0, 1'b0, "R8");
        do_frame(1'b1, 1'b0, 1'b0, "R8");
        // Corrupt first successor carries no confirmation.
        do_reset();
        do_slot(2, "R10"); do_frame(1'b1, 1'b1, 1'b1, "R2");
        do_slot(SELF_ID, "R6");
        do_slot(2, "R10"); do_frame(1'b0, 1'b1, 1'b1, "R7");
        do_slot(3, "R10"); do_frame(1'b1, 1'b1, 1'b0, "R7");
        // Minority clique and the tie case.
        do_reset();
        do_slot(2, "R10"); do_frame(1'b0, 1'b1, 1'b1, "R3");
        do_slot(3, "R10"); do_frame(1'b0, 1'b1, 1'b1, "R3");
        do_slot(0, "R10"); do_frame(1'b1, 1'b1, 1'b1, "R2");
        do_slot(SELF_ID, "R5");
        do_reset();
        do_slot(2, "R10"); do_frame(1'b1, 1'b1, 1'b1, "R2");
        do_slot(3, "R10"); do_frame(1'b0, 1'b1, 1'b1, "R3");
        do_slot(SELF_ID, "R5");
        // Saturation of both counters.
        do_reset();
        do_slot(2, "R10");
        for (int i = 0; i < CMAX + 4; i++) do_frame(1'b1, 1'b1, 1'b1, "R2");
        for (int i = 0; i < CMAX + 4; i++) do_frame(1'b0, 1'b1, 1'b1, "R3");
        // Random rounds.
        do_reset();
        for (int r = 0; r < 400; r++) begin
            if (m_sil && ($urandom % 2 == 0)) do_reset();
            for (int s = 0; s < N_NODES; s++) begin
                do_slot(s, (s == SELF_ID) ? "R5" : "R10");
                if (s == SELF_ID) begin
                    if ($urandom % 8 == 0)
                        do_frame(1'($urandom), 1'($urandom), 1'($urandom), "R4");
                end else begin
                    bit ok, a1, a2;
                    ok = ($urandom % 8) != 0;
                    a1 = ($urandom % 6) != 0;
                    a2 = ($urandom % 6) != 0;
                    do_frame(ok, a1, a2, ok ? "R2" : "R3");
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule